// File: doc/BRIEF.md
# Pipelined Delayed-Error LMS Adaptive FIR Filter

The block is an adaptive FIR filter with a fixed number of taps whose coefficients follow the least-mean-squares rule. The error fed back to the coefficient update is a few samples old. That lets the product, adder-tree and error stages each carry a pipeline register, so no combinational loop runs from the output back to the weights. Each input sample arrives with a desired-response sample. The block returns the filter output, the error (desired minus output) and the full coefficient vector.

All state advances only on cycles where `valid_i` is high, so every delay below is counted in accepted samples and not in clock cycles. The taps are summed in groups of `GRP` products, and each group has its own register ahead of the final sum. The step size is a power of two, set by the number of extra right-shift positions applied to the error-times-input product. Data, error and weights are signed fixed point numbers with `FRAC` fraction bits (Q1.15 at the default width).

Top module: `dlms_filter`

## Requirements
- R1: After reset, `valid_o` is 0 and `y_o`, `e_o` and every weight in `w_o` are 0.
- R2: Number the accepted samples n = 0, 1, ... from reset or clear. The result for sample n appears on `y_o`/`e_o`, with `valid_o` high, in the cycle after sample n+3 is accepted. `valid_o` is 0 after an accepted sample with n < 3.
- R3: The output is y(n) = sat(Σk sat(rnd(w_k·x(n−k) / 2^FRAC))). Tap k=0 is the newest sample, samples before the first accepted one count as 0, and the weights used are those just after the update made when sample n was accepted. rnd means adding half an LSB and then shifting right arithmetically. sat clamps to the signed DW-bit range.
- R4: The error is e(n) = sat(d(n) − y(n)).
- R5: When sample t is accepted, each weight becomes w_k ← sat(w_k + sat(rnd(e(t−4)·x(t−4−k) / 2^(FRAC+mu)))), where mu is `mu_shift_i` in that cycle. Weights do not change while the first four samples after reset or clear are accepted (adaptation delay 4).
- R6: Products, the sum, the error, the update term and the weights saturate and never wrap, even at full-scale inputs.
- R7: A cycle with `valid_i` low changes no weight and no output value, and `valid_o` is 0 in the following cycle.
- R8: A cycle with `clr_i` high (it wins over `valid_i`) sets all weights, pipeline contents and `valid_o` to 0, and sample numbering restarts at 0.
- R9: Each step of `mu_shift_i` halves the update term, and a different value may be applied on every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of weights and pipeline |
| valid_i | input | 1 | Accept x_i and d_i this cycle |
| x_i | input | DW | Input sample, signed fixed point |
| d_i | input | DW | Desired response for x_i |
| mu_shift_i | input | MUW | Extra right shift of the update term |
| valid_o | output | 1 | y_o and e_o carry a new result |
| y_o | output | DW | Filter output |
| e_o | output | DW | Error d − y |
| w_o | output | NTAPS*DW | Weights, tap k at bits k*DW +: DW |

## Verification
The main stimulus is a system-identification run. Small random inputs drive a fixed unknown FIR plant, and random idle cycles are mixed in. This separates a correct four-sample adaptation delay and stage alignment from an off-by-one in the tap copies or the desired-sample delay, because either fault puts the weights on a different path. A full-scale alternating run with `mu_shift_i` at 0 drives every saturation point. A run with `mu_shift_i` chosen at random on each sample shows whether the shift is applied per sample and rounded correctly. Clear pulses in the middle of a stream check that the pipeline restarts and the weights do not carry over.

// File: rtl/dlms_pkg.sv
package dlms_pkg;
  localparam int unsigned XW = 48;

  function automatic logic signed [XW-1:0] rnd_shr(input logic signed [XW-1:0] v,
                                                    input int unsigned sh);
    logic signed [XW-1:0] half;
    half = (sh == 0) ? '0 : (XW'(1) <<< (sh - 1));
    return (v + half) >>> sh;
  endfunction

  function automatic logic signed [XW-1:0] sat_to(input logic signed [XW-1:0] v,
                                                   input int unsigned w);
    logic signed [XW-1:0] hi, lo;
    hi = (XW'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/dlms_tap_line.sv
module dlms_tap_line #(
  parameter int NTAPS = 8,
  parameter int DW    = 16,
  parameter int ALIGN = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       en_i,
  input  logic [DW-1:0]              x_i,
  output logic [NTAPS-1:0][DW-1:0]   taps_o,
  output logic [NTAPS-1:0][DW-1:0]   al_o
);
  // stage 0 is the live delay line, stage ALIGN lines up with the error register
  logic [ALIGN:0][NTAPS-1:0][DW-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else if (clr_i) begin
      stg_q <= '0;
    end else if (en_i) begin
      stg_q[0] <= {stg_q[0][NTAPS-2:0], x_i};
      for (int s = 1; s <= ALIGN; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign taps_o = stg_q[0];
  assign al_o   = stg_q[ALIGN];
endmodule

// File: rtl/dlms_fir_path.sv
module dlms_fir_path
  import dlms_pkg::*;
#(
  parameter int NTAPS = 8,
  parameter int DW    = 16,
  parameter int FRAC  = 15,
  parameter int GRP   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      en_i,
  input  logic [NTAPS-1:0][DW-1:0]  taps_i,
  input  logic [NTAPS*DW-1:0]       w_i,
  input  logic [DW-1:0]             d_i,
  output logic                      ev_o,
  output logic                      valid_o,
  output logic [DW-1:0]             y_o,
  output logic [DW-1:0]             e_o
);
  localparam int NGRP = NTAPS / GRP;
  localparam int AW   = DW + $clog2(NTAPS) + 1;

  logic [NTAPS-1:0][DW-1:0] p_q;
  logic [NGRP-1:0][AW-1:0]  gs_q;
  logic [2:0][DW-1:0]       d_q;
  logic [3:0]               v_q;
  logic [DW-1:0]            y_q, e_q;
  logic signed [XW-1:0]     ysum, ysat, ediff, esat;

  for (genvar k = 0; k < NTAPS; k++) begin : g_mul
    logic [DW-1:0]        wk, tk;
    logic signed [XW-1:0] pf, ps;
    assign wk = w_i[k*DW +: DW];
    assign tk = taps_i[k];
    always_comb begin
      pf = $signed({{(XW-DW){wk[DW-1]}}, wk}) * $signed({{(XW-DW){tk[DW-1]}}, tk});
      ps = sat_to(rnd_shr(pf, FRAC), DW);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      p_q[k] <= '0;
      else if (clr_i)   p_q[k] <= '0;
      else if (en_i)    p_q[k] <= ps[DW-1:0];
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [AW-1:0] gs;
    always_comb begin
      gs = '0;
      for (int j = 0; j < GRP; j++)
        gs = gs + {{(AW-DW){p_q[g*GRP+j][DW-1]}}, p_q[g*GRP+j]};
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      gs_q[g] <= '0;
      else if (clr_i)   gs_q[g] <= '0;
      else if (en_i)    gs_q[g] <= gs;
    end
  end

  always_comb begin
    ysum = '0;
    for (int g = 0; g < NGRP; g++)
      ysum = ysum + $signed({{(XW-AW){gs_q[g][AW-1]}}, gs_q[g]});
    ysat  = sat_to(ysum, DW);
    ediff = $signed({{(XW-DW){d_q[2][DW-1]}}, d_q[2]}) - ysat;
    esat  = sat_to(ediff, DW);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0; v_q <= '0; y_q <= '0; e_q <= '0; valid_o <= 1'b0;
    end else if (clr_i) begin
      d_q <= '0; v_q <= '0; y_q <= '0; e_q <= '0; valid_o <= 1'b0;
    end else begin
      valid_o <= en_i & v_q[2];
      if (en_i) begin
        d_q <= {d_q[1:0], d_i};
        v_q <= {v_q[2:0], 1'b1};
        y_q <= ysat[DW-1:0];
        e_q <= esat[DW-1:0];
      end
    end
  end

  assign ev_o = v_q[3];
  assign y_o  = y_q;
  assign e_o  = e_q;
endmodule

// File: rtl/dlms_coef_update.sv
module dlms_coef_update
  import dlms_pkg::*;
#(
  parameter int NTAPS = 8,
  parameter int DW    = 16,
  parameter int FRAC  = 15,
  parameter int MUW   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      upd_i,
  input  logic [DW-1:0]             e_i,
  input  logic [NTAPS-1:0][DW-1:0]  al_i,
  input  logic [MUW-1:0]            mu_i,
  output logic [NTAPS*DW-1:0]       w_o
);
  int unsigned sh;
  assign sh = FRAC + int'(mu_i);

  for (genvar k = 0; k < NTAPS; k++) begin : g_coef
    logic [DW-1:0]        w_q, xk;
    logic signed [XW-1:0] ex, up, ws;
    assign xk = al_i[k];
    always_comb begin
      ex = $signed({{(XW-DW){e_i[DW-1]}}, e_i}) * $signed({{(XW-DW){xk[DW-1]}}, xk});
      up = sat_to(rnd_shr(ex, sh), DW);
      ws = sat_to($signed({{(XW-DW){w_q[DW-1]}}, w_q}) + up, DW);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     w_q <= '0;
      else if (clr_i)  w_q <= '0;
      else if (upd_i)  w_q <= ws[DW-1:0];
    end
    assign w_o[k*DW +: DW] = w_q;
  end
endmodule

// File: rtl/dlms_filter.sv
module dlms_filter #(
  parameter int NTAPS = 8,
  parameter int DW    = 16,
  parameter int FRAC  = 15,
  parameter int GRP   = 4,
  parameter int MUW   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                valid_i,
  input  logic [DW-1:0]       x_i,
  input  logic [DW-1:0]       d_i,
  input  logic [MUW-1:0]      mu_shift_i,
  output logic                valid_o,
  output logic [DW-1:0]       y_o,
  output logic [DW-1:0]       e_o,
  output logic [NTAPS*DW-1:0] w_o
);
  // product, group and output registers: error is ALIGN samples behind the tap line
  localparam int ALIGN = 3;

  logic [NTAPS-1:0][DW-1:0] taps, al;
  logic                     ev;

  dlms_tap_line #(.NTAPS(NTAPS), .DW(DW), .ALIGN(ALIGN)) u_taps (
    .clk_i, .rst_ni, .clr_i, .en_i(valid_i), .x_i,
    .taps_o(taps), .al_o(al)
  );

  dlms_fir_path #(.NTAPS(NTAPS), .DW(DW), .FRAC(FRAC), .GRP(GRP)) u_fir (
    .clk_i, .rst_ni, .clr_i, .en_i(valid_i), .taps_i(taps), .w_i(w_o), .d_i,
    .ev_o(ev), .valid_o, .y_o, .e_o
  );

  dlms_coef_update #(.NTAPS(NTAPS), .DW(DW), .FRAC(FRAC), .MUW(MUW)) u_coef (
    .clk_i, .rst_ni, .clr_i, .upd_i(valid_i & ev), .e_i(e_o), .al_i(al),
    .mu_i(mu_shift_i), .w_o
  );
endmodule

// File: rtl/dlms_filter_chk.sv
module dlms_filter_chk #(
  parameter int NTAPS = 8,
  parameter int DW    = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clr_i,
  input logic                valid_i,
  input logic                valid_o,
  input logic [DW-1:0]       y_o,
  input logic [DW-1:0]       e_o,
  input logic [NTAPS*DW-1:0] w_o
);
  logic [2:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (valid_i && cnt_q != 3'd7) cnt_q <= cnt_q + 3'd1;
  end

  AST_IDLE_WEIGHTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(w_o)); // R7
  AST_IDLE_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> ($stable(y_o) && $stable(e_o) && !valid_o)); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (w_o == '0 && !valid_o && y_o == '0)); // R8
  AST_EARLY_NO_ADAPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clr_i && cnt_q < 3'd4) |=> $stable(w_o)); // R5
  AST_FIRST_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cnt_q >= 3'd4)); // R2
endmodule

bind dlms_filter dlms_filter_chk #(.NTAPS(NTAPS), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .valid_i(valid_i),
  .valid_o(valid_o), .y_o(y_o), .e_o(e_o), .w_o(w_o)
);

// File: tb/tb_dlms_filter.sv
`timescale 1ns/1ps
module tb_dlms_filter;
  localparam int NT = 8, DW = 16, FRAC = 15, GRP = 4, MUW = 4;

  logic clk = 1'b0, rst_ni = 1'b0, clr_i = 1'b0, valid_i = 1'b0;
  logic [DW-1:0] x_i = '0, d_i = '0;
  logic [MUW-1:0] mu_shift_i = '0;
  logic valid_o;
  logic [DW-1:0] y_o, e_o;
  logic [NT*DW-1:0] w_o;

  int checks = 0, errors = 0;
  bit done = 0;
  longint mw[NT];
  longint hx[4096], hy[4096], he[4096];
  longint plant[NT];
  int n = 0;

  always #2.5 clk = ~clk;

  dlms_filter #(.NTAPS(NT), .DW(DW), .FRAC(FRAC), .GRP(GRP), .MUW(MUW)) dut (
    .clk_i(clk), .rst_ni, .clr_i, .valid_i, .x_i, .d_i, .mu_shift_i,
    .valid_o, .y_o, .e_o, .w_o
  );

  function automatic longint sat(longint v);
    longint hi = (64'sd1 <<< (DW - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  function automatic longint rsh(longint v, int sh);
    if (sh == 0) return v;
    return (v + (64'sd1 <<< (sh - 1))) >>> sh;
  endfunction

  function automatic longint xat(int i);
    return (i >= 0) ? hx[i] : 0;
  endfunction

  function automatic longint sv(logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint wget(int k);
    return sv(w_o[k*DW +: DW]);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    n = 0;
    for (int k = 0; k < NT; k++) mw[k] = 0;
  endtask

  task automatic step(longint x, longint d, int mu, string tag);
    longint y;
    @(negedge clk);
    valid_i = 1'b1; clr_i = 1'b0;
    x_i = DW'(x); d_i = DW'(d); mu_shift_i = MUW'(mu);
    @(posedge clk); #1;
    valid_i = 1'b0;
    if (n >= 4)
      for (int k = 0; k < NT; k++)
        mw[k] = sat(mw[k] + sat(rsh(he[n-4] * xat(n - 4 - k), FRAC + mu)));
    hx[n] = x;
    y = 0;
    for (int k = 0; k < NT; k++) y += sat(rsh(mw[k] * xat(n - k), FRAC));
    hy[n] = sat(y);
    he[n] = sat(d - hy[n]);
    for (int k = 0; k < NT; k++)
      chk(wget(k) == mw[k], {tag, " R5 weight"}, wget(k), mw[k]);
    chk(valid_o == (n >= 3), "R2 valid_o", longint'(valid_o), longint'(n >= 3));
    if (n >= 3) begin
      chk(sv(y_o) == hy[n-3], {tag, " R3 y"}, sv(y_o), hy[n-3]);
      chk(sv(e_o) == he[n-3], {tag, " R4 e"}, sv(e_o), he[n-3]);
    end
    n++;
  endtask

  task automatic idle();
    logic [NT*DW-1:0] w0;
    logic [DW-1:0] y0, e0;
    w0 = w_o; y0 = y_o; e0 = e_o;
    @(negedge clk);
    valid_i = 1'b0; x_i = DW'($urandom); d_i = DW'($urandom);
    @(posedge clk); #1;
    chk(w_o == w0, "R7 idle weights", longint'(w_o[DW-1:0]), longint'(w0[DW-1:0]));
    chk(y_o == y0 && e_o == e0, "R7 idle outputs", sv(y_o), sv(y0));
    chk(!valid_o, "R7 idle valid_o", longint'(valid_o), 0);
  endtask

  task automatic clear();
    @(negedge clk);
    clr_i = 1'b1; valid_i = 1'b1; x_i = DW'(16'h4000); d_i = DW'(16'h2000);
    @(posedge clk); #1;
    clr_i = 1'b0; valid_i = 1'b0;
    chk(w_o == '0, "R8 clear weights", longint'(w_o[DW-1:0]), 0);
    chk(!valid_o && y_o == '0 && e_o == '0, "R8 clear outputs", sv(y_o), 0);
    model_clear();
  endtask

  function automatic longint plant_out(longint x);
    longint s = 0;
    for (int k = 0; k < NT; k++) s += rsh(plant[k] * ((k == 0) ? x : xat(n - k)), FRAC);
    return sat(s);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint x;
    void'($urandom(32'd20240611));
    for (int k = 0; k < NT; k++) plant[k] = longint'(((k * 37 + 11) % 64) - 32) * 512;
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;
    chk(!valid_o, "R1 reset valid_o", longint'(valid_o), 0);
    chk(y_o == '0 && e_o == '0, "R1 reset y/e", sv(y_o), 0);
    chk(w_o == '0, "R1 reset weights", longint'(w_o[DW-1:0]), 0);

    // system identification with idle gaps
    for (int i = 0; i < 400; i++) begin
      x = longint'($signed(16'($urandom))) >>> 2;
      step(x, plant_out(x), 2, "sysid");
      if ($urandom_range(9) == 0) idle();
    end

    // restart mid-stream
    clear();
    step(16'sd8192, 16'sd4096, 0, "restart");
    idle();
    for (int i = 0; i < 20; i++) begin
      x = longint'($signed(16'($urandom))) >>> 3;
      step(x, plant_out(x), 1, "restart");
    end

    // full-scale saturation
    clear();
    for (int i = 0; i < 40; i++) begin
      x = (i % 2 == 0) ? 32767 : -32768;
      step(x, (i % 3 == 0) ? -32768 : 32767, 0, "R6 sat");
    end

    // per-sample step size
    clear();
    for (int i = 0; i < 200; i++) begin
      x = longint'($signed(16'($urandom))) >>> 1;
      step(x, plant_out(x), $urandom_range(15), "R9 mu");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule